// File: doc/BRIEF.md
# Taken-Branch History Recorder with Loop Timing

This block keeps a circular history of the most recent taken branches retired by a core. Each retire-side branch event that is both valid and taken becomes one record, holding the branch address, its destination and the value of a free-running cycle counter in that cycle. Because every record closes one basic block (the run of instructions between two consecutive taken branches), the history describes the last basic blocks the core executed. Software reads any record through an indexed port. Index zero is the most recent record and higher indices reach further back.

Alongside the history, a loop meter watches the same stream of records. It is configured with two branch addresses: one marks the back edge of an outer loop and the other the back edge of an inner loop. When two successive records carry the outer address, the meter reports the cycle distance between them as the latency of one outer iteration. It also reports how many inner-branch records fell between them, which is the inner trip count. A freeze input holds the history still so that software can read a consistent snapshot. A clear input empties the history and restarts the meter.

Top module: `tbr_loop_monitor`

## Requirements
- R1: After synchronous reset the fill count is 0, the measurement-valid flag is low and every read index reports rd_valid low with all data fields zero.
- R2: An event is recorded only when br_valid and br_taken are both 1. An event with either bit at 0 changes neither the fill count nor any readable record.
- R3: A record stores br_pc, br_target and the cycle_now value of the cycle in which the event is presented. It is readable on the read port from the next cycle on.
- R4: The read port is combinational. rd_idx 0 returns the newest record and rd_idx k returns the record written k events before it. When rd_idx is not below the fill count, rd_valid is 0 and all data fields read 0.
- R5: The history holds DEPTH records (default 32). The fill count saturates at DEPTH, and once it is full each new record replaces the oldest one.
- R6: While freeze is 1, no record is written and the latency, trip-count and valid outputs do not change.
- R7: When clear is 1, the next cycle shows a fill count of 0, the valid flag at 0, and latency and trip count at 0. A branch event in the same cycle as clear is dropped.
- R8: When a record's PC equals cfg_outer_pc and an earlier outer record exists since the last reset or clear, iter_latency becomes the difference between the two records' timestamps, taken modulo 2^32.
- R9: When an outer record closes an interval, trip_count becomes the number of records with PC equal to cfg_inner_pc written since the previous outer record. A record whose PC matches both configured values counts only as an outer record.
- R10: meas_valid stays 0 until the second outer record since reset or clear. It goes to 1 in the cycle after that record is presented.
- R11: The inner count saturates at 2^CNT_W-1 (255 by default) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A branch retires this cycle |
| br_taken | input | 1 | The retiring branch was taken |
| br_pc | input | 32 | Address of the branch instruction |
| br_target | input | 32 | Destination address of the branch |
| cycle_now | input | 32 | Free-running cycle counter |
| freeze | input | 1 | Hold the history and meter |
| clear | input | 1 | Empty the history and restart the meter |
| cfg_outer_pc | input | 32 | Branch address of the outer loop back edge |
| cfg_inner_pc | input | 32 | Branch address of the inner loop back edge |
| rd_idx | input | 5 | Read index, 0 = newest |
| rd_valid | output | 1 | The indexed record exists |
| rd_pc | output | 32 | Branch address of the indexed record |
| rd_target | output | 32 | Destination of the indexed record |
| rd_stamp | output | 32 | Timestamp of the indexed record |
| fill_count | output | 6 | Number of records held |
| iter_latency | output | 32 | Cycles between the last two outer records |
| trip_count | output | 8 | Inner records between the last two outer records |
| meas_valid | output | 1 | Latency and trip count are meaningful |

## Verification
Two functions can act in the same cycle: the clear input, and a taken outer-loop branch that would both write a record and close a measured interval. The bench provokes this by driving clear together with an outer-branch event after a valid measurement already exists. The expected result is that the event is dropped: in the next cycle the fill count is 0 and meas_valid is 0, and one further outer record still leaves meas_valid low. Freeze combined with an outer event is judged the same way, by checking that the fill count, iter_latency and the valid flag do not move.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

    localparam int PC_W = 32;
    localparam int TS_W = 32;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] target;
        logic [TS_W-1:0] stamp;
    } tbr_rec_t;

    // Elapsed cycles between two timestamps, tolerant of counter wrap.
    function automatic logic [TS_W-1:0] stamp_delta(input logic [TS_W-1:0] newer,
                                                    input logic [TS_W-1:0] older);
        return newer - older;
    endfunction

endpackage

// File: rtl/tbr_ring.sv
module tbr_ring
    import tbr_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             wr_en,
    input  tbr_rec_t         wr_rec,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output tbr_rec_t         rd_rec,
    output logic [IDX_W:0]   fill
);

    tbr_rec_t         store [DEPTH];
    logic [IDX_W-1:0] wr_ptr;
    logic [IDX_W-1:0] rd_slot;

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_ptr] <= wr_rec;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else if (wr_en) begin
            wr_ptr <= (int'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
            if (int'(fill) < DEPTH) fill <= fill + 1'b1;
        end
    end

    always_comb begin
        int s;
        s        = (int'(wr_ptr) + DEPTH - 1 - int'(rd_idx)) % DEPTH;
        rd_slot  = IDX_W'(s);
        rd_valid = ({1'b0, rd_idx} < fill);
        rd_rec   = rd_valid ? store[rd_slot] : '0;
    end

    assert_fill_bound_R5: assert property (@(posedge clk) disable iff (rst)
        int'(fill) <= DEPTH);

    assert_fill_step_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clear && int'(fill) < DEPTH) |=> (fill == $past(fill) + 1'b1));

    assert_clear_empty_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> (fill == '0));

endmodule

// File: rtl/tbr_loop_meter.sv
module tbr_loop_meter
    import tbr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             rec_en,
    input  tbr_rec_t         rec,
    input  logic [PC_W-1:0]  cfg_outer,
    input  logic [PC_W-1:0]  cfg_inner,
    output logic [TS_W-1:0]  latency,
    output logic [CNT_W-1:0] trips,
    output logic             meas_valid
);

    logic [TS_W-1:0]  last_outer;
    logic             seen_outer;
    logic [CNT_W-1:0] inner_run;
    logic             hit_outer;
    logic             hit_inner;

    assign hit_outer = rec_en && (rec.pc == cfg_outer);
    assign hit_inner = rec_en && (rec.pc == cfg_inner) && !hit_outer;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            last_outer <= '0;
            seen_outer <= 1'b0;
            inner_run  <= '0;
            latency    <= '0;
            trips      <= '0;
            meas_valid <= 1'b0;
        end else if (hit_outer) begin
            if (seen_outer) begin
                latency    <= stamp_delta(rec.stamp, last_outer);
                trips      <= inner_run;
                meas_valid <= 1'b1;
            end
            last_outer <= rec.stamp;
            seen_outer <= 1'b1;
            inner_run  <= '0;
        end else if (hit_inner && (inner_run != '1)) begin
            inner_run <= inner_run + 1'b1;
        end
    end

    assert_clear_drop_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> !meas_valid);

    assert_valid_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(meas_valid) |-> $past(rec_en && (rec.pc == cfg_outer)));

    assert_lat_change_R8: assert property (@(posedge clk) disable iff (rst)
        (!$stable(latency) && meas_valid) |-> $past(rec_en && (rec.pc == cfg_outer)));

endmodule

// File: rtl/tbr_loop_monitor.sv
module tbr_loop_monitor
    import tbr_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_valid,
    input  logic             br_taken,
    input  logic [PC_W-1:0]  br_pc,
    input  logic [PC_W-1:0]  br_target,
    input  logic [TS_W-1:0]  cycle_now,
    input  logic             freeze,
    input  logic             clear,
    input  logic [PC_W-1:0]  cfg_outer_pc,
    input  logic [PC_W-1:0]  cfg_inner_pc,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [PC_W-1:0]  rd_pc,
    output logic [PC_W-1:0]  rd_target,
    output logic [TS_W-1:0]  rd_stamp,
    output logic [IDX_W:0]   fill_count,
    output logic [TS_W-1:0]  iter_latency,
    output logic [CNT_W-1:0] trip_count,
    output logic             meas_valid
);

    tbr_rec_t new_rec;
    tbr_rec_t out_rec;
    logic     rec_en;

    assign rec_en  = br_valid && br_taken && !freeze && !clear;
    assign new_rec = '{pc: br_pc, target: br_target, stamp: cycle_now};

    tbr_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .wr_en    (rec_en),
        .wr_rec   (new_rec),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_rec   (out_rec),
        .fill     (fill_count)
    );

    tbr_loop_meter #(.CNT_W(CNT_W)) u_meter (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .rec_en     (rec_en),
        .rec        (new_rec),
        .cfg_outer  (cfg_outer_pc),
        .cfg_inner  (cfg_inner_pc),
        .latency    (iter_latency),
        .trips      (trip_count),
        .meas_valid (meas_valid)
    );

    assign rd_pc     = out_rec.pc;
    assign rd_target = out_rec.target;
    assign rd_stamp  = out_rec.stamp;

    assert_untaken_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (!(br_valid && br_taken) && !clear) |=> $stable(fill_count));

    assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (freeze && !clear) |=> ($stable(fill_count) && $stable(iter_latency)
                                && $stable(trip_count) && $stable(meas_valid)));

endmodule

// File: tb/tbr_loop_monitor_tb.sv
`timescale 1ns/1ps
module tbr_loop_monitor_tb;
    import tbr_pkg::*;

    localparam int DEPTH = 32;
    localparam int CNT_W = 8;
    localparam logic [31:0] OUTER = 32'h0000_1000;
    localparam logic [31:0] INNER = 32'h0000_1040;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_valid = 0, br_taken = 0, freeze = 0, clear = 0;
    logic [31:0] br_pc = 0, br_target = 0, cycle_now = 0;
    logic [31:0] cfg_outer_pc = OUTER, cfg_inner_pc = INNER;
    logic [4:0]  rd_idx = 0;
    logic        rd_valid, meas_valid;
    logic [31:0] rd_pc, rd_target, rd_stamp, iter_latency;
    logic [5:0]  fill_count;
    logic [7:0]  trip_count;

    tbr_loop_monitor #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_taken(br_taken),
        .br_pc(br_pc), .br_target(br_target), .cycle_now(cycle_now),
        .freeze(freeze), .clear(clear), .cfg_outer_pc(cfg_outer_pc),
        .cfg_inner_pc(cfg_inner_pc), .rd_idx(rd_idx), .rd_valid(rd_valid),
        .rd_pc(rd_pc), .rd_target(rd_target), .rd_stamp(rd_stamp),
        .fill_count(fill_count), .iter_latency(iter_latency),
        .trip_count(trip_count), .meas_valid(meas_valid)
    );

    always #4 clk = ~clk;

    int unsigned n_vec = 0, n_bad = 0;
    bit          finished = 0;

    logic [31:0] m_pc [DEPTH];
    logic [31:0] m_tg [DEPTH];
    logic [31:0] m_ts [DEPTH];
    int          m_wp = 0, m_cnt = 0, m_inner = 0, m_trip = 0;
    logic [31:0] m_last = 0, m_lat = 0, ts_now = 32'd100;
    bit          m_seen = 0, m_valid = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_step(input bit v, input bit tk, input logic [31:0] pc,
                              input logic [31:0] tg, input logic [31:0] ts,
                              input bit frz, input bit clr);
        if (clr) begin
            m_cnt = 0; m_wp = 0; m_seen = 0; m_inner = 0;
            m_valid = 0; m_lat = 0; m_trip = 0; m_last = 0;
        end else if (v && tk && !frz) begin
            m_pc[m_wp] = pc; m_tg[m_wp] = tg; m_ts[m_wp] = ts;
            m_wp = (m_wp + 1) % DEPTH;
            if (m_cnt < DEPTH) m_cnt++;
            if (pc == cfg_outer_pc) begin
                if (m_seen) begin
                    m_lat = ts - m_last; m_trip = m_inner; m_valid = 1;
                end
                m_last = ts; m_seen = 1; m_inner = 0;
            end else if (pc == cfg_inner_pc && m_inner < 255) begin
                m_inner++;
            end
        end
    endtask

    task automatic cyc(input string req, input bit v, input bit tk,
                       input logic [31:0] pc, input logic [31:0] tg,
                       input bit frz, input bit clr);
        br_valid = v; br_taken = tk; br_pc = pc; br_target = tg;
        freeze = frz; clear = clr; cycle_now = ts_now;
        @(posedge clk);
        model_step(v, tk, pc, tg, ts_now, frz, clr);
        @(negedge clk);
        ts_now = ts_now + 32'd1 + ($urandom % 5);
        chk(req, "fill_count", 64'(fill_count), 64'(m_cnt));
        chk(req, "meas_valid", 64'(meas_valid), 64'(m_valid));
        chk(req, "iter_latency", 64'(iter_latency), 64'(m_lat));
        chk(req, "trip_count", 64'(trip_count), 64'(m_trip));
    endtask

    task automatic scan(input string req);
        br_valid = 0; br_taken = 0; freeze = 0; clear = 0;
        for (int i = 0; i < DEPTH; i++) begin
            int s;
            rd_idx = 5'(i);
            #0.2;
            s = (m_wp + DEPTH - 1 - i) % DEPTH;
            chk(req, "rd_valid", 64'(rd_valid), 64'(i < m_cnt));
            chk(req, "rd_pc", 64'(rd_pc), (i < m_cnt) ? 64'(m_pc[s]) : 64'd0);
            chk(req, "rd_target", 64'(rd_target), (i < m_cnt) ? 64'(m_tg[s]) : 64'd0);
            chk(req, "rd_stamp", 64'(rd_stamp), (i < m_cnt) ? 64'(m_ts[s]) : 64'd0);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1", "fill_count", 64'(fill_count), 64'd0);
        chk("R1", "meas_valid", 64'(meas_valid), 64'd0);
        scan("R1");
        // R2: not-taken and invalid events are ignored
        cyc("R2", 1, 0, 32'h2000, 32'h2100, 0, 0);
        cyc("R2", 0, 1, 32'h2004, 32'h2200, 0, 0);
        scan("R2");
        // R3 / R4: one record, read back newest-first
        cyc("R3", 1, 1, 32'h2000, 32'h2100, 0, 0);
        cyc("R4", 1, 1, 32'h3000, 32'h3300, 0, 0);
        scan("R4");
        // R10 / R9 / R8: outer, three inner, other, outer
        cyc("R10", 1, 1, OUTER, 32'h0f00, 0, 0);
        chk("R10", "valid after first outer", 64'(meas_valid), 64'd0);
        for (int i = 0; i < 3; i++) cyc("R9", 1, 1, INNER, 32'h1010, 0, 0);
        cyc("R9", 1, 1, 32'h5000, 32'h5008, 0, 0);
        cyc("R8", 1, 1, OUTER, 32'h0f00, 0, 0);
        chk("R9", "trip of three", 64'(trip_count), 64'd3);
        // R8: timestamp wrap
        ts_now = 32'hFFFF_FFF0;
        cyc("R8", 1, 1, OUTER, 32'h0f00, 0, 0);
        ts_now = 32'h0000_0010;
        cyc("R8", 1, 1, OUTER, 32'h0f00, 0, 0);
        chk("R8", "wrapped latency", 64'(iter_latency), 64'h20);
        // R9: a record matching both addresses counts as outer
        cfg_inner_pc = OUTER;
        cyc("R9", 1, 1, OUTER, 32'h0f00, 0, 0);
        cyc("R9", 1, 1, OUTER, 32'h0f00, 0, 0);
        chk("R9", "dual match trip", 64'(trip_count), 64'd0);
        cfg_inner_pc = INNER;
        // R6: freeze blocks record and measurement
        cyc("R6", 1, 1, OUTER, 32'h0f00, 1, 0);
        cyc("R6", 1, 1, INNER, 32'h0f00, 1, 0);
        scan("R6");
        // R7: clear wins over a simultaneous outer event
        cyc("R7", 1, 1, OUTER, 32'h0f00, 0, 1);
        chk("R7", "fill after clear", 64'(fill_count), 64'd0);
        cyc("R10", 1, 1, OUTER, 32'h0f00, 0, 0);
        chk("R10", "valid after one outer post clear", 64'(meas_valid), 64'd0);
        // R5: overfill wraps and keeps the newest DEPTH records
        for (int i = 0; i < 40; i++)
            cyc("R5", 1, 1, 32'h8000 + 32'(i * 4), $urandom, 0, 0);
        chk("R5", "saturated fill", 64'(fill_count), 64'd32);
        scan("R5");
        // R11: inner count saturation
        cyc("R11", 1, 1, OUTER, 32'h0f00, 0, 0);
        for (int i = 0; i < 300; i++) cyc("R11", 1, 1, INNER, 32'h1010, 0, 0);
        cyc("R11", 1, 1, OUTER, 32'h0f00, 0, 0);
        chk("R11", "saturated trip", 64'(trip_count), 64'd255);
        // random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned sel;
            logic [31:0] pc;
            sel = $urandom % 8;
            pc  = (sel < 2) ? OUTER : (sel < 5) ? INNER : (32'h9000 + ($urandom % 16) * 4);
            cyc("R8", ($urandom % 8) != 0, ($urandom % 6) != 0, pc, $urandom,
                ($urandom % 20) == 0, ($urandom % 150) == 0);
            if (n % 64 == 63) scan("R4");
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule